// File: doc/BRIEF.md
# Staged-Operand Accumulator ALU

This block is an 8-bit arithmetic and logic datapath. It has an accumulator, a carry flag and a zero flag. The operation unit never takes an operand straight from the accumulator. Instead, two hidden staging registers feed it:

- the first-operand register, which is loaded from the accumulator, from a constant input, from the data bus, or cleared to zero;
- the second-operand register, which is loaded from the data bus.

Because of this staging, an executed result can be written into the accumulator on the same clock edge without racing back into the operand that produced it.

A microsequencer drives the block one micro-step at a time. A step can load the first operand, load the second operand, or execute an operation, and steps may be combined in one cycle. The accumulator has no direct load path from the bus. Any value placed in it passes through the operation unit, for example as a pass-through of the first operand. Loading the constant `0x01` into the first operand provides increment and decrement sources while the accumulator keeps its contents. Loading the first operand from the bus lets an operation run without involving the accumulator. Everything runs on one clock with a synchronous active-high reset.

Top module: `staged_acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, both flags and both staging registers become zero. After reset, executing pass (`101`) or add (`000`) without loading anything yields `0x00`.
- R2: When `stepExec` is high at an edge, `accOut`, `carryOut` and `zeroOut` show the result of the operation on the two staging registers after that edge. The staging registers keep their values, so repeating an execute gives the same result again.
- R3: `opSel` encodes the operations as follows: `000` first+second, `001` first−second, `010` AND, `011` OR, `100` XOR, `101` pass first operand, `110` first+1, `111` first−1. All results are taken modulo 256.
- R4: `carryOut` is the carry out of `000` and `110`, and the borrow of `001` and `111`. It is 0 after `010`, `011`, `100` and `101`.
- R5: `zeroOut` is 1 exactly when the executed 8-bit result is `0x00`.
- R6: With `stepAct` high, the first operand loads according to `actSrc`: `00` takes the accumulator, `01` takes `constIn`, `10` takes `busIn`, and `11` clears it to zero.
- R7: With `stepTmp` high, the second operand loads from `busIn`.
- R8: In a cycle without `stepExec`, the accumulator and both flags keep their values, whatever operand loads occur.
- R9: If an operand load and an execute fall in the same cycle, the execute uses the old operand. The newly loaded value is used from the next cycle on. This holds for both staging registers.
- R10: Loading the first operand from the accumulator in the same cycle as an execute captures the accumulator value from before that execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stepAct | input | 1 | Load the first staging register |
| actSrc | input | 2 | First-operand source: 00 accumulator, 01 constant, 10 bus, 11 zero |
| constIn | input | 8 | Constant source for the first operand |
| stepTmp | input | 1 | Load the second staging register from the bus |
| stepExec | input | 1 | Execute `opSel` and write the accumulator and flags |
| opSel | input | 3 | Operation code |
| busIn | input | 8 | Internal data bus |
| accOut | output | 8 | Accumulator |
| carryOut | output | 1 | Carry/borrow flag |
| zeroOut | output | 1 | Zero flag |

## Verification
The collision that matters is between an execute and an operand reload in the same cycle. It also covers an execute together with a first-operand load taken from the accumulator that the execute is about to overwrite. The bench provokes it by raising `stepExec` together with `stepAct` or `stepTmp` in a single step. It judges the outcome twice. First, it checks that the accumulator reflects the old operand right after that edge. Second, it runs a follow-up pass or add to show that the new operand landed. Repeated executes with no reload confirm that a result never feeds back into its own operand.

// File: rtl/staged_acc_pkg.sv
package staged_acc_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_PASS = 3'b101,
    OP_INC  = 3'b110,
    OP_DEC  = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    SRC_ACC   = 2'b00,
    SRC_CONST = 2'b01,
    SRC_BUS   = 2'b10,
    SRC_ZERO  = 2'b11
  } actSrc_e;

  typedef struct packed {
    logic    actLoad;
    actSrc_e actSel;
    logic    tmpLoad;
    logic    exec;
    aluOp_e  op;
  } strobes_t;

endpackage

// File: rtl/staged_acc_ctrl.sv
module staged_acc_ctrl
  import staged_acc_pkg::*;
(
  input  logic       rst,
  input  logic       stepAct,
  input  logic [1:0] actSrc,
  input  logic       stepTmp,
  input  logic       stepExec,
  input  logic [2:0] opSel,
  output strobes_t   strobes
);

  // Strobes are suppressed during reset so the datapath sees only the clear.
  always_comb begin
    strobes.actLoad = stepAct & ~rst;
    strobes.actSel  = actSrc_e'(actSrc);
    strobes.tmpLoad = stepTmp & ~rst;
    strobes.exec    = stepExec & ~rst;
    strobes.op      = aluOp_e'(opSel);
  end

endmodule

// File: rtl/staged_acc_opunit.sv
module staged_acc_opunit
  import staged_acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluOp_e           op,
  output logic [WIDTH-1:0] result,
  output logic             carry
);

  localparam int WIDE = WIDTH + 1;
  localparam logic [WIDE-1:0] ONE = WIDE'(1);

  logic [WIDE-1:0] wideA, wideB, wideRes;
  logic            isArith;

  assign wideA = {1'b0, opA};
  assign wideB = {1'b0, opB};

  always_comb begin
    isArith = 1'b0;
    unique case (op)
      OP_ADD:  begin wideRes = wideA + wideB; isArith = 1'b1; end
      OP_SUB:  begin wideRes = wideA - wideB; isArith = 1'b1; end
      OP_AND:  wideRes = wideA & wideB;
      OP_OR:   wideRes = wideA | wideB;
      OP_XOR:  wideRes = wideA ^ wideB;
      OP_PASS: wideRes = wideA;
      OP_INC:  begin wideRes = wideA + ONE; isArith = 1'b1; end
      OP_DEC:  begin wideRes = wideA - ONE; isArith = 1'b1; end
      default: wideRes = '0;
    endcase
  end

  assign result = wideRes[WIDTH-1:0];
  assign carry  = isArith & wideRes[WIDTH];

endmodule

// File: rtl/staged_acc_datapath.sv
module staged_acc_datapath
  import staged_acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         strobes,
  input  logic [WIDTH-1:0] constIn,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] accQ,
  output logic             carryQ,
  output logic             zeroQ
);

  logic [WIDTH-1:0] actQ, tmpQ, actNext, aluRes;
  logic             aluCarry;

  always_comb begin
    unique case (strobes.actSel)
      SRC_ACC:   actNext = accQ;
      SRC_CONST: actNext = constIn;
      SRC_BUS:   actNext = busIn;
      default:   actNext = '0;
    endcase
  end

  staged_acc_opunit #(.WIDTH(WIDTH)) opUnit (
    .opA   (actQ),
    .opB   (tmpQ),
    .op    (strobes.op),
    .result(aluRes),
    .carry (aluCarry)
  );

  // Staging registers: operands for the ALU, never the accumulator itself.
  always_ff @(posedge clk) begin
    if (rst) begin
      actQ <= '0;
      tmpQ <= '0;
    end else begin
      if (strobes.actLoad) actQ <= actNext;
      if (strobes.tmpLoad) tmpQ <= busIn;
    end
  end

  // Accumulator and flags: written only by an execute.
  always_ff @(posedge clk) begin
    if (rst) begin
      accQ   <= '0;
      carryQ <= 1'b0;
      zeroQ  <= 1'b0;
    end else if (strobes.exec) begin
      accQ   <= aluRes;
      carryQ <= aluCarry;
      zeroQ  <= (aluRes == '0);
    end
  end

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.exec |=> $stable(accQ) && $stable(carryQ) && $stable(zeroQ));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.exec |=> zeroQ == (accQ == '0));

  assert_logic_no_carry_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.exec && (strobes.op inside {OP_AND, OP_OR, OP_XOR, OP_PASS}) |=> !carryQ);

  assert_sub_old_operands_R9: assert property (@(posedge clk) disable iff (rst)
    strobes.exec && strobes.op == OP_SUB |=> accQ == $past(actQ - tmpQ));

  assert_operand_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.actLoad && !strobes.tmpLoad |=> $stable(actQ) && $stable(tmpQ));

endmodule

// File: rtl/staged_acc_alu.sv
module staged_acc_alu
  import staged_acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepAct,
  input  logic [1:0]       actSrc,
  input  logic [WIDTH-1:0] constIn,
  input  logic             stepTmp,
  input  logic             stepExec,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] accOut,
  output logic             carryOut,
  output logic             zeroOut
);

  strobes_t strobes;

  staged_acc_ctrl ctrl (
    .rst     (rst),
    .stepAct (stepAct),
    .actSrc  (actSrc),
    .stepTmp (stepTmp),
    .stepExec(stepExec),
    .opSel   (opSel),
    .strobes (strobes)
  );

  staged_acc_datapath #(.WIDTH(WIDTH)) datapath (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .constIn(constIn),
    .busIn  (busIn),
    .accQ   (accOut),
    .carryQ (carryOut),
    .zeroQ  (zeroOut)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> accOut == '0 && !carryOut && !zeroOut);

endmodule

// File: tb/staged_acc_alu_test.sv
module staged_acc_alu_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stepAct = 0, stepTmp = 0, stepExec = 0;
  logic [1:0] actSrc = 2'b00;
  logic [7:0] constIn = 8'h00, busIn = 8'h00;
  logic [2:0] opSel = 3'b000;
  logic [7:0] accOut;
  logic       carryOut, zeroOut;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  staged_acc_alu uut (
    .clk(clk), .rst(rst), .stepAct(stepAct), .actSrc(actSrc), .constIn(constIn),
    .stepTmp(stepTmp), .stepExec(stepExec), .opSel(opSel), .busIn(busIn),
    .accOut(accOut), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  // {first operand, second operand, op, expected acc, carry, zero}
  localparam int NVEC = 16;
  localparam logic [28:0] VECS [NVEC] = '{
    {8'h3C, 8'h0A, 3'b000, 8'h46, 1'b0, 1'b0},
    {8'hF0, 8'h20, 3'b000, 8'h10, 1'b1, 1'b0},
    {8'h80, 8'h80, 3'b000, 8'h00, 1'b1, 1'b1},
    {8'h10, 8'h20, 3'b001, 8'hF0, 1'b1, 1'b0},
    {8'h50, 8'h50, 3'b001, 8'h00, 1'b0, 1'b1},
    {8'h50, 8'h21, 3'b001, 8'h2F, 1'b0, 1'b0},
    {8'hCC, 8'hAA, 3'b010, 8'h88, 1'b0, 1'b0},
    {8'h0F, 8'hF0, 3'b010, 8'h00, 1'b0, 1'b1},
    {8'h0F, 8'hF0, 3'b011, 8'hFF, 1'b0, 1'b0},
    {8'hCC, 8'hAA, 3'b100, 8'h66, 1'b0, 1'b0},
    {8'h5A, 8'h5A, 3'b100, 8'h00, 1'b0, 1'b1},
    {8'h7E, 8'h00, 3'b101, 8'h7E, 1'b0, 1'b0},
    {8'hFF, 8'h00, 3'b110, 8'h00, 1'b1, 1'b1},
    {8'h41, 8'h00, 3'b110, 8'h42, 1'b0, 1'b0},
    {8'h00, 8'h00, 3'b111, 8'hFF, 1'b1, 1'b0},
    {8'h01, 8'h00, 3'b111, 8'h00, 1'b0, 1'b1}
  };

  // One micro-step: drive on a falling edge, hold across one rising edge.
  task automatic step(input bit aL, input logic [1:0] src, input bit tL, input bit ex,
                      input logic [2:0] op, input logic [7:0] bus, input logic [7:0] k);
    stepAct = aL; actSrc = src; stepTmp = tL; stepExec = ex;
    opSel = op; busIn = bus; constIn = k;
    @(negedge clk);
    stepAct = 0; stepTmp = 0; stepExec = 0;
  endtask

  task automatic check(input string req, input logic [7:0] expAcc,
                       input logic expC, input logic expZ);
    checks++;
    if (accOut !== expAcc || carryOut !== expC || zeroOut !== expZ) begin
      fails++;
      $display("FAIL %s: acc=%h c=%b z=%b expected acc=%h c=%b z=%b",
               req, accOut, carryOut, zeroOut, expAcc, expC, expZ);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1 reset state", 8'h00, 1'b0, 1'b0);
    step(0, 2'b00, 0, 1, 3'b101, 8'h00, 8'h00);
    check("R1 first operand cleared", 8'h00, 1'b0, 1'b1);
    step(0, 2'b00, 0, 1, 3'b000, 8'h00, 8'h00);
    check("R1 second operand cleared", 8'h00, 1'b0, 1'b1);

    // Vector table: R2 R3 R4 R5 R6 R7
    foreach (VECS[i]) begin
      step(1, 2'b10, 0, 0, 3'b000, VECS[i][28:21], 8'h00);
      step(0, 2'b00, 1, 0, 3'b000, VECS[i][20:13], 8'h00);
      step(0, 2'b00, 0, 1, VECS[i][12:10], 8'h00, 8'h00);
      check("R3/R4/R5 vector", VECS[i][9:2], VECS[i][1], VECS[i][0]);
    end

    // R2: repeated execute does not feed back
    step(1, 2'b10, 0, 0, 3'b000, 8'h05, 8'h00);
    step(0, 2'b00, 1, 0, 3'b000, 8'h03, 8'h00);
    step(0, 2'b00, 0, 1, 3'b000, 8'h00, 8'h00);
    check("R2 add", 8'h08, 1'b0, 1'b0);
    step(0, 2'b00, 0, 1, 3'b000, 8'h00, 8'h00);
    check("R2 repeat add unchanged", 8'h08, 1'b0, 1'b0);

    // R6 constant source, R8 acc unchanged by load alone
    step(1, 2'b01, 0, 0, 3'b000, 8'hEE, 8'h01);
    check("R8 acc holds on const load", 8'h08, 1'b0, 1'b0);
    step(0, 2'b00, 0, 1, 3'b101, 8'h00, 8'h00);
    check("R6 const source", 8'h01, 1'b0, 1'b0);
    step(1, 2'b00, 0, 0, 3'b000, 8'h00, 8'h00);
    step(0, 2'b00, 0, 1, 3'b000, 8'h00, 8'h00);
    check("R6 accumulator source", 8'h04, 1'b0, 1'b0);
    step(1, 2'b11, 0, 0, 3'b000, 8'hAB, 8'hCD);
    step(0, 2'b00, 0, 1, 3'b101, 8'h00, 8'h00);
    check("R6 zero source", 8'h00, 1'b0, 1'b1);

    // R9 first operand load colliding with execute
    step(1, 2'b10, 0, 0, 3'b000, 8'h10, 8'h00);
    step(1, 2'b10, 0, 1, 3'b101, 8'h20, 8'h00);
    check("R9 exec uses old first operand", 8'h10, 1'b0, 1'b0);
    step(0, 2'b00, 0, 1, 3'b101, 8'h00, 8'h00);
    check("R9 new first operand next cycle", 8'h20, 1'b0, 1'b0);

    // R7/R9 second operand load colliding with execute
    step(0, 2'b00, 1, 0, 3'b000, 8'h01, 8'h00);
    step(0, 2'b00, 1, 1, 3'b000, 8'h07, 8'h00);
    check("R9 exec uses old second operand", 8'h21, 1'b0, 1'b0);
    step(0, 2'b00, 0, 1, 3'b000, 8'h00, 8'h00);
    check("R7 new second operand next cycle", 8'h27, 1'b0, 1'b0);

    // R10 capture accumulator in the cycle it is overwritten
    step(1, 2'b00, 0, 1, 3'b110, 8'h00, 8'h00);
    check("R10 exec inc on old operand", 8'h21, 1'b0, 1'b0);
    step(0, 2'b00, 0, 1, 3'b101, 8'h00, 8'h00);
    check("R10 captured old accumulator", 8'h27, 1'b0, 1'b0);

    // R8 flags hold through loads without execute
    step(1, 2'b10, 0, 0, 3'b000, 8'hFF, 8'h00);
    step(0, 2'b00, 0, 1, 3'b110, 8'h00, 8'h00);
    check("R4 inc wrap", 8'h00, 1'b1, 1'b1);
    step(1, 2'b10, 1, 0, 3'b011, 8'h55, 8'h00);
    check("R8 flags hold on loads", 8'h00, 1'b1, 1'b1);

    // R1 mid-run reset
    step(0, 2'b00, 0, 1, 3'b101, 8'h00, 8'h00);
    check("R2 pass before reset", 8'h55, 1'b0, 1'b0);
    rst = 1;
    step(0, 2'b00, 0, 1, 3'b101, 8'h00, 8'h00);
    rst = 0;
    check("R1 mid-run reset", 8'h00, 1'b0, 1'b0);
    step(0, 2'b00, 0, 1, 3'b011, 8'h00, 8'h00);
    check("R1 operands cleared by reset", 8'h00, 1'b0, 1'b1);

    finishRun();
  end

endmodule